// File: doc/BRIEF.md
# Indexed Configuration RAM with Checksum

This block is a small setup memory of 64 bytes that is reached through two byte ports. An index port selects a location and a data port reads or writes it. Writing the index stores only its low seven bits. The data path decodes only the low six of those bits, so every location appears at two index values. At reset the contents are loaded from a parameter image. Nothing in the memory keeps time.

When the first data-port request arrives after reset, a checksum engine runs once before that request is served. It walks a fixed window of bytes, one byte per clock, and adds them into a 16-bit sum. It then stores the sum in two fixed locations, with the high byte at the lower address. While the engine runs it raises a busy flag and holds the ready signal low. A data-port write that is waiting for ready changes nothing. Reads are combinational: the read data always shows the byte that the current index selects.

Top module: `cfgram_cksum`

## Requirements
- R1: After reset the index reads 0, busy and ready are both 0, and every byte holds the value from the reset image.
- R2: A write to the index port stores the written byte masked to 7 bits (bit 7 is dropped). The new index appears on `idx_q` after the next rising edge.
- R3: The data port addresses the memory with only bits 5:0 of the index. For example, index 0x55 reaches location 0x15.
- R4: The first data request after reset (`dat_rd` or `dat_wr`) sets `cks_busy` on the next edge. Busy stays high for exactly 29 cycles, and `dat_ready` stays low until busy falls. A write that is stalled in this way does not change the memory.
- R5: The checksum is the 16-bit sum of locations 0x10 through 0x2C inclusive. Its high byte goes to 0x2E and its low byte to 0x2F. Bytes at 0x0F and 0x2D are not part of the sum. With the default image the result is 0x01 at 0x2E and 0xAE at 0x2F.
- R6: Once the checksum has run, `dat_ready` stays high. The checksum is never computed again, so later writes inside the window leave 0x2E and 0x2F unchanged.
- R7: `dat_rdata` shows the selected byte combinationally. A write with ready high updates that byte on the rising edge.
- R8: In the default image, location 0x16 holds 0x02 and location 0x15 holds 0x80. Together they form the base memory size 0x0280 (640 KB).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| idx_wr | input | 1 | Index port write strobe |
| idx_wdata | input | 8 | Byte written to the index port |
| idx_q | output | 7 | Stored index |
| dat_rd | input | 1 | Data port read request |
| dat_wr | input | 1 | Data port write request |
| dat_wdata | input | 8 | Byte written through the data port |
| dat_rdata | output | 8 | Byte at the selected location |
| dat_ready | output | 1 | Data port served (checksum finished) |
| cks_busy | output | 1 | Checksum engine running |

## Verification
- A new index is due one rising edge after `idx_wr` is sampled.
- Read data follows the index within the same cycle.
- A served write shows up one edge after it is sampled.
- The checksum sets busy one edge after the first request and clears it 29 edges later. Ready rises on that same edge.
- The bench drives every input on a falling edge and samples on the following falling edge, half a period clear of each active edge.
- The bench counts falling edges with busy high. It then compares the stored checksum bytes against a sum worked out by hand from the default image.

// File: rtl/cfgram_cksum.sv
module cfgram_cksum #(
  parameter int AW        = 6,
  parameter int IW        = 7,
  parameter int DW        = 8,
  parameter int SUM_FIRST = 'h10,
  parameter int SUM_LAST  = 'h2C,
  parameter int CK_HI     = 'h2E,
  parameter int CK_LO     = 'h2F,
  parameter logic [(2**AW)*DW-1:0] INIT_IMAGE =
      (512'h40 << 128) | (512'hB1 << 136) | (512'h80 << 168) |
      (512'h02 << 176) | (512'h3B << 192) | (512'hFF << 120) |
      (512'hFF << 360) | (512'hCC << 368) | (512'hCC << 376)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          idx_wr,
  input  logic [DW-1:0] idx_wdata,
  output logic [IW-1:0] idx_q,
  input  logic          dat_rd,
  input  logic          dat_wr,
  input  logic [DW-1:0] dat_wdata,
  output logic [DW-1:0] dat_rdata,
  output logic          dat_ready,
  output logic          cks_busy
);
  localparam int DEPTH = 2**AW;
  localparam int CKW   = 2*DW;
  localparam logic [DW-1:0] IDX_MASK = DW'((2**IW) - 1);

  logic [DW-1:0]  mem [DEPTH];
  logic [IW-1:0]  idx;
  logic [AW-1:0]  ptr;
  logic [CKW-1:0] acc;
  logic           busy, done;

  wire [AW-1:0]  sel    = idx[AW-1:0];
  wire           req    = dat_rd | dat_wr;
  wire [CKW-1:0] acc_nx = acc + CKW'(mem[ptr]);
  wire           last   = (ptr == AW'(SUM_LAST));

  assign idx_q     = idx;
  assign dat_rdata = mem[sel];
  assign dat_ready = done;
  assign cks_busy  = busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= INIT_IMAGE[i*DW +: DW];
      idx  <= '0;
      ptr  <= AW'(SUM_FIRST);
      acc  <= '0;
      busy <= 1'b0;
      done <= 1'b0;
    end else begin
      if (idx_wr) idx <= IW'(idx_wdata & IDX_MASK);
      if (busy) begin
        acc <= acc_nx;
        ptr <= ptr + 1'b1;
        if (last) begin
          busy <= 1'b0;
          done <= 1'b1;
          mem[AW'(CK_HI)] <= acc_nx[CKW-1:DW];
          mem[AW'(CK_LO)] <= acc_nx[DW-1:0];
        end
      end else if (!done && req) begin
        busy <= 1'b1;
      end
      if (done && dat_wr) mem[sel] <= dat_wdata;
    end
  end
endmodule

module cfgram_cksum_chk #(
  parameter int DW   = 8,
  parameter int IW   = 7,
  parameter int SPAN = 29
) (
  input logic          clk,
  input logic          rst_n,
  input logic          idx_wr,
  input logic [DW-1:0] idx_wdata,
  input logic [IW-1:0] idx_q,
  input logic          dat_wr,
  input logic [DW-1:0] dat_wdata,
  input logic [DW-1:0] dat_rdata,
  input logic          dat_ready,
  input logic          cks_busy
);
  logic [15:0] run;
  always_ff @(posedge clk) begin
    if (!rst_n) run <= '0;
    else if (cks_busy) run <= run + 1'b1;
  end

  a_r4_stall_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    cks_busy |-> !dat_ready);
  a_r4_busy_length: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cks_busy) |-> run == 16'(SPAN));
  a_r6_ready_sticks: assert property (@(posedge clk) disable iff (!rst_n)
    dat_ready |=> dat_ready);
  a_r2_index_masked: assert property (@(posedge clk) disable iff (!rst_n)
    idx_wr |=> idx_q == $past(idx_wdata[IW-1:0]));
  a_r7_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_wr && dat_ready && !idx_wr) |=> dat_rdata == $past(dat_wdata));
endmodule

bind cfgram_cksum cfgram_cksum_chk #(.DW(DW), .IW(IW), .SPAN(SUM_LAST - SUM_FIRST + 1))
  u_chk (.clk(clk), .rst_n(rst_n), .idx_wr(idx_wr), .idx_wdata(idx_wdata),
         .idx_q(idx_q), .dat_wr(dat_wr), .dat_wdata(dat_wdata),
         .dat_rdata(dat_rdata), .dat_ready(dat_ready), .cks_busy(cks_busy));

// File: tb/cfgram_cksum_bench.sv
module cfgram_cksum_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       idx_wr = 1'b0;
  logic [7:0] idx_wdata = '0;
  logic [6:0] idx_q;
  logic       dat_rd = 1'b0;
  logic       dat_wr = 1'b0;
  logic [7:0] dat_wdata = '0;
  logic [7:0] dat_rdata;
  logic       dat_ready, cks_busy;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  cfgram_cksum u_cfgram_cksum (
    .clk(clk), .rst_n(rst_n), .idx_wr(idx_wr), .idx_wdata(idx_wdata),
    .idx_q(idx_q), .dat_rd(dat_rd), .dat_wr(dat_wr), .dat_wdata(dat_wdata),
    .dat_rdata(dat_rdata), .dat_ready(dat_ready), .cks_busy(cks_busy));

  task automatic check(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic set_index(input logic [7:0] v);
    idx_wr = 1'b1; idx_wdata = v;
    @(negedge clk);
    idx_wr = 1'b0;
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R1 index", idx_q, 0);
    check("R1 busy", cks_busy, 0);
    check("R1 ready", dat_ready, 0);
    check("R1 byte 0x00", dat_rdata, 8'h00);
    set_index(8'h2E);
    check("R1 byte 0x2E before checksum", dat_rdata, 8'hCC);
  endtask

  task automatic t_base_mem;
    set_index(8'h16);
    check("R8 high byte 0x16", dat_rdata, 8'h02);
    set_index(8'h15);
    check("R8 low byte 0x15", dat_rdata, 8'h80);
  endtask

  task automatic t_index_alias;
    set_index(8'hD5);
    check("R2 index masked", idx_q, 7'h55);
    check("R3 alias 0x55 -> 0x15", dat_rdata, 8'h80);
    set_index(8'h7F);
    check("R2 index top value", idx_q, 7'h7F);
    check("R3 alias 0x7F -> 0x3F", dat_rdata, 8'h00);
  endtask

  task automatic t_first_access;
    int n;
    set_index(8'h20);
    dat_wr = 1'b1; dat_wdata = 8'h55;
    n = 0;
    @(negedge clk);
    check("R4 busy after first request", cks_busy, 1);
    while (cks_busy && n < 100) begin
      n++;
      check("R4 ready low while busy", dat_ready, 0);
      if (n == 10) check("R4 stalled write has no effect", dat_rdata, 8'h00);
      @(negedge clk);
    end
    check("R4 busy cycle count", n, 29);
    check("R4 ready after checksum", dat_ready, 1);
    @(negedge clk);
    dat_wr = 1'b0;
    check("R7 served write landed", dat_rdata, 8'h55);
  endtask

  task automatic t_checksum;
    set_index(8'h2E);
    check("R5 checksum high at 0x2E", dat_rdata, 8'h01);
    set_index(8'h2F);
    check("R5 checksum low at 0x2F", dat_rdata, 8'hAE);
    set_index(8'h2D);
    check("R5 byte 0x2D untouched", dat_rdata, 8'hFF);
  endtask

  task automatic t_once_and_rw;
    set_index(8'h11);
    dat_wr = 1'b1; dat_wdata = 8'h3C;
    check("R7 read before write edge", dat_rdata, 8'hB1);
    @(negedge clk);
    dat_wr = 1'b0;
    check("R7 write visible after edge", dat_rdata, 8'h3C);
    dat_rd = 1'b1;
    repeat (40) @(negedge clk);
    check("R6 no second busy", cks_busy, 0);
    check("R6 ready stays high", dat_ready, 1);
    dat_rd = 1'b0;
    set_index(8'h2F);
    check("R6 checksum low unchanged", dat_rdata, 8'hAE);
    set_index(8'h6E);
    check("R6 checksum high unchanged via alias", dat_rdata, 8'h01);
  endtask

  initial begin
    #(4 * 100000);
    errors++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_base_mem();
    t_index_alias();
    t_first_access();
    t_checksum();
    t_once_and_rw();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule